// File: doc/BRIEF.md
# Stochastic Min-Sum Check Node

This block is the check-node processing element of a layered min-sum LDPC decoder. It receives one signed log-likelihood ratio from each of its variable-node neighbours. For every edge it returns the extrinsic message: the smallest magnitude among the other edges, with a sign equal to the parity of the other edges' signs. The magnitude minimum uses no comparator tree. Each stored magnitude is turned into a unary bitstream by comparing it, cycle after cycle, against one shared pseudo-random value. Because every input sees the same comparison value, the streams are fully correlated. The AND of several streams is then the stream of the smallest magnitude, and counting its ones recovers that magnitude.

The comparison sequence comes from a maximal-length LFSR extended with the all-zero state, so one run of 2^MAG_W cycles presents every threshold exactly once. The recovered count is therefore the exact minimum, not an estimate. A one-cycle `start` pulse captures a full set of inputs. A one-cycle `done` pulse marks the moment all extrinsic outputs are valid, and they are held until the next `start`. The outputs stay within the saturated range that the variable-node adders expect.

Top module: `scn_check_node`

## Requirements
- R1: Each input edge is a two's-complement value of MAG_W+1 bits; bit MAG_W is its sign (1 = negative). Its magnitude is the absolute value, and the most negative code (-2^MAG_W, e.g. -32) saturates to magnitude 2^MAG_W-1 (31).
- R2: The magnitude of output edge i equals the exact minimum of the input magnitudes of all edges other than i; the edge's own input never takes part.
- R3: The sign of output edge i is the XOR of the sign bits of all input edges other than i. The output is written in two's complement of MAG_W+1 bits: the negated magnitude when that sign is 1, otherwise the magnitude.
- R4: When the extrinsic minimum is 0, the output edge is exactly 0 whatever its computed sign.
- R5: `done` is high for exactly one cycle. It rises in the cycle that follows the 33rd rising clock edge counted from the edge that samples `start`, that is, after 2^MAG_W stream cycles.
- R6: After `done`, `llr_out` keeps its value and `done` stays low until the next `start`.
- R7: A `start` during a run abandons that run with no `done` for it. The new inputs are taken, and the full latency of R5 counts from the new `start`.
- R8: Within one run the comparison sequence takes every value from 0 to 2^MAG_W-1 exactly once, so a stream bit (1 when the magnitude is strictly greater than the current value) is 1 in exactly `magnitude` cycles.
- R9: After reset, `done` is 0 and every output edge is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that captures `llr_in` and begins a run |
| llr_in | input | DEG*(MAG_W+1) | Input messages; edge k occupies bits [k*(MAG_W+1) +: MAG_W+1] |
| done | output | 1 | One-cycle pulse: all outputs valid |
| llr_out | output | DEG*(MAG_W+1) | Extrinsic messages, same packing as `llr_in` |

## Verification
The only timed result is the full set of extrinsic outputs. It is due with `done` in the cycle that follows the 33rd rising edge after `start` is sampled, and it stays valid from then on. The driver stamps each expected item with that cycle number. The monitor samples on the falling edge, pops the item when `done` is seen, and compares both the value and the arrival cycle. A `done` with nothing queued counts as a failure, which catches a run that should have been abandoned. Holding is checked by reading the outputs again many cycles after `done`, and the pulse width by reading `done` on the cycle after it.

// File: rtl/scn_pkg.sv
package scn_pkg;
  typedef enum logic {
    SCN_IDLE = 1'b0,
    SCN_RUN  = 1'b1
  } scn_state_e;
endpackage

// File: rtl/scn_rng.sv
// Shared comparison-value source: Fibonacci LFSR whose cycle is stretched
// to include the all-zero state, giving a permutation of 0 .. 2^W-1.
module scn_rng #(
  parameter int          W    = 5,
  parameter logic [W-1:0] TAPS = 5'b10100,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] val
);

  function automatic logic [W-1:0] next_state(input logic [W-1:0] s);
    logic fb;
    logic low_zero;
    fb       = ^(s & TAPS);
    low_zero = (s[W-2:0] == '0);
    // flipping feedback when all but the oldest bit are zero inserts 0
    return {s[W-2:0], fb ^ low_zero};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= SEED;
    else if (load) val <= SEED;
    else if (step) val <= next_state(val);
  end

endmodule

// File: rtl/scn_ctrl.sv
module scn_ctrl
  import scn_pkg::*;
#(
  parameter int MAG_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last_cycle,
  output logic done
);

  scn_state_e         state;
  logic [MAG_W-1:0]   cyc_cnt;

  assign busy       = (state == SCN_RUN);
  assign last_cycle = busy && (&cyc_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SCN_IDLE;
      cyc_cnt <= '0;
      done    <= 1'b0;
    end else if (start) begin
      state   <= SCN_RUN;
      cyc_cnt <= '0;
      done    <= 1'b0;
    end else if (busy) begin
      cyc_cnt <= cyc_cnt + 1'b1;
      done    <= last_cycle;
      if (last_cycle) state <= SCN_IDLE;
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/scn_edge_lane.sv
// One extrinsic output: AND of the other edges' streams, counted.
module scn_edge_lane #(
  parameter int DEG   = 6,
  parameter int IDX   = 0,
  parameter int MAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [DEG-1:0]   stream_bits,
  input  logic [DEG-1:0]   sign_bits,
  output logic [MAG_W-1:0] ones_count,
  output logic             and_bit,
  output logic             sign_out
);

  function automatic logic others_and(input logic [DEG-1:0] v);
    logic r;
    r = 1'b1;
    for (int j = 0; j < DEG; j++)
      if (j != IDX) r = r & v[j];
    return r;
  endfunction

  function automatic logic others_xor(input logic [DEG-1:0] v);
    logic r;
    r = 1'b0;
    for (int j = 0; j < DEG; j++)
      if (j != IDX) r = r ^ v[j];
    return r;
  endfunction

  assign and_bit  = others_and(stream_bits);
  assign sign_out = others_xor(sign_bits);

  // ones never exceed 2^MAG_W-1 since the top threshold is never beaten
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ones_count <= '0;
    else if (clear)         ones_count <= '0;
    else if (en && and_bit) ones_count <= ones_count + 1'b1;
  end

endmodule

// File: rtl/scn_check_node.sv
module scn_check_node #(
  parameter int              DEG       = 6,
  parameter int              MAG_W     = 5,
  parameter logic [MAG_W-1:0] LFSR_TAPS = 5'b10100,
  parameter logic [MAG_W-1:0] LFSR_SEED = 5'b00001
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [DEG*(MAG_W+1)-1:0]   llr_in,
  output logic                       done,
  output logic [DEG*(MAG_W+1)-1:0]   llr_out
);

  localparam int LLR_W = MAG_W + 1;

  function automatic logic [MAG_W-1:0] mag_sat(input logic [LLR_W-1:0] v);
    logic [LLR_W-1:0] neg;
    neg = -v;
    if (!v[LLR_W-1])      return v[MAG_W-1:0];
    else if (neg[LLR_W-1]) return '1;
    else                  return neg[MAG_W-1:0];
  endfunction

  function automatic logic [LLR_W-1:0] to_llr(input logic s, input logic [MAG_W-1:0] m);
    logic [LLR_W-1:0] e;
    e = {1'b0, m};
    return s ? -e : e;
  endfunction

  logic [MAG_W-1:0]     mag_q [DEG];
  logic [DEG-1:0]       sign_q;
  logic [MAG_W-1:0]     rng_val;
  logic                 busy;
  logic                 last_cycle;
  logic [DEG-1:0]       stream_bits;
  logic [DEG-1:0]       and_bits;
  logic [DEG-1:0]       sign_out;
  logic [MAG_W-1:0]     edge_cnt [DEG];
  logic [DEG*MAG_W-1:0] cnt_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEG; k++) mag_q[k] <= '0;
      sign_q <= '0;
    end else if (start) begin
      for (int k = 0; k < DEG; k++) begin
        mag_q[k]  <= mag_sat(llr_in[k*LLR_W +: LLR_W]);
        sign_q[k] <= llr_in[k*LLR_W + MAG_W];
      end
    end
  end

  scn_ctrl #(.MAG_W(MAG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .last_cycle (last_cycle),
    .done       (done)
  );

  scn_rng #(.W(MAG_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .step  (busy),
    .val   (rng_val)
  );

  for (genvar g = 0; g < DEG; g++) begin : g_edge
    assign stream_bits[g] = (mag_q[g] > rng_val);

    scn_edge_lane #(.DEG(DEG), .IDX(g), .MAG_W(MAG_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start),
      .en          (busy),
      .stream_bits (stream_bits),
      .sign_bits   (sign_q),
      .ones_count  (edge_cnt[g]),
      .and_bit     (and_bits[g]),
      .sign_out    (sign_out[g])
    );

    assign cnt_flat[g*MAG_W +: MAG_W] = edge_cnt[g];
    assign llr_out[g*LLR_W +: LLR_W]  = to_llr(sign_out[g], edge_cnt[g]);
  end

endmodule

// File: rtl/scn_check_node_chk.sv
module scn_check_node_chk #(
  parameter int DEG   = 6,
  parameter int MAG_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic [MAG_W-1:0]         rng_val,
  input logic [DEG-1:0]           sign_q,
  input logic [DEG-1:0]           sign_out,
  input logic [DEG*MAG_W-1:0]     cnt_flat,
  input logic [DEG*(MAG_W+1)-1:0] llr_out
);

  localparam int STREAM_LEN = 1 << MAG_W;

  logic [MAG_W:0]          run_cycles;
  logic [STREAM_LEN-1:0]   seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cycles <= '0;
      seen       <= '0;
    end else if (start) begin
      run_cycles <= '0;
      seen       <= '0;
    end else if (busy) begin
      run_cycles       <= run_cycles + 1'b1;
      seen[rng_val]    <= 1'b1;
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cycles == (MAG_W+1)'(STREAM_LEN)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(llr_out));

  assert_abandon_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && busy));

  assert_full_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&seen));

  for (genvar g = 0; g < DEG; g++) begin : g_mono
    assert_count_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt_flat[g*MAG_W +: MAG_W] >= $past(cnt_flat[g*MAG_W +: MAG_W])));
  end

  if (DEG % 2 == 0) begin : g_par
    // each input sign feeds an odd number of outputs when DEG is even
    assert_sign_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((^sign_out) == (^sign_q)));
  end

endmodule

bind scn_check_node scn_check_node_chk #(.DEG(DEG), .MAG_W(MAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .rng_val  (rng_val),
  .sign_q   (sign_q),
  .sign_out (sign_out),
  .cnt_flat (cnt_flat),
  .llr_out  (llr_out)
);

// File: tb/scn_check_node_tb_top.sv
`timescale 1ns/1ps
module scn_check_node_tb_top;

  localparam int DEG   = 6;
  localparam int MAG_W = 5;
  localparam int LLR_W = MAG_W + 1;
  localparam int VW    = DEG * LLR_W;
  localparam int LAT   = 33;

  typedef struct {
    logic [VW-1:0] exp;
    longint        due;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] llr_in = '0;
  logic          done;
  logic [VW-1:0] llr_out;

  item_t         sb[$];
  logic [VW-1:0] last_exp = '0;
  longint        cyc = 0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scn_check_node #(.DEG(DEG), .MAG_W(MAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .llr_in(llr_in), .done(done), .llr_out(llr_out)
  );

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference: R1 magnitude, R2 minimum of others, R3/R4 sign and zero
  function automatic logic [VW-1:0] model(input logic [VW-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < DEG; i++) begin
      int best;
      bit neg;
      best = 1 << MAG_W;
      neg  = 0;
      for (int j = 0; j < DEG; j++) begin
        if (j != i) begin
          int x;
          int a;
          x = $signed(v[j*LLR_W +: LLR_W]);
          a = (x < 0) ? -x : x;
          if (a > (1 << MAG_W) - 1) a = (1 << MAG_W) - 1;
          if (a < best) best = a;
          if (x < 0) neg = !neg;
        end
      end
      r[i*LLR_W +: LLR_W] = LLR_W'(neg ? -best : best);
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] pack6(input int a0, input int a1, input int a2,
                                          input int a3, input int a4, input int a5);
    logic [VW-1:0] r;
    r = {LLR_W'(a5), LLR_W'(a4), LLR_W'(a3), LLR_W'(a2), LLR_W'(a1), LLR_W'(a0)};
    return r;
  endfunction

  task automatic drive(input logic [VW-1:0] v, input bit expect_result);
    @(negedge clk);
    llr_in = v;
    start  = 1'b1;
    if (expect_result) sb.push_back('{model(v), cyc + LAT});
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops an expected item each time done is seen
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R7: actual done with empty scoreboard expected no done");
      end else begin
        item_t it;
        it = sb.pop_front();
        check("R2/R3 extrinsic outputs", llr_out, it.exp);
        n_chk++;
        if (cyc != it.due) begin
          n_fail++;
          $display("FAIL R5: actual done at cycle %0d expected %0d", cyc, it.due);
        end
        last_exp = it.exp;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 done after reset", {{(VW-1){1'b0}}, done}, '0);
    check("R9 outputs after reset", llr_out, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 positive values, own input excluded
    drive(pack6(3, 7, 12, 20, 25, 31), 1); drain();
    // R3 mixed signs
    drive(pack6(-5, 9, -14, 2, -30, 17), 1); drain();
    // R2 duplicated minimum
    drive(pack6(4, 4, 10, -4, 22, 8), 1); drain();
    // R4 one zero edge
    drive(pack6(0, 5, -9, 12, 3, -7), 1); drain();
    // R4 all zero with negative signs elsewhere
    drive(pack6(0, 0, -1, 0, 0, 0), 1); drain();
    // R1 saturation of the most negative code
    drive(pack6(-32, -32, 31, -32, 31, -31), 1); drain();
    // R8 small against large magnitudes: needs thresholds 0 and 30
    drive(pack6(1, 31, 31, 31, 31, 31), 1); drain();
    drive(pack6(31, 31, 31, 31, 31, 31), 1); drain();

    // R5 pulse width and R6 hold after done
    @(negedge clk);
    check("R5 done one cycle", {{(VW-1){1'b0}}, done}, '0);
    repeat (15) @(negedge clk);
    check("R6 outputs held", llr_out, last_exp);

    // R7 restart mid-run: only the second run reports
    drive(pack6(9, 9, 9, 9, 9, 9), 0);
    repeat (10) @(negedge clk);
    drive(pack6(-2, 6, 15, -27, 11, 19), 1); drain();
    repeat (5) @(negedge clk);
    check("R6 outputs held after restart", llr_out, last_exp);

    // R8 exact minimum over random patterns
    for (int n = 0; n < 40; n++) begin
      logic [VW-1:0] v;
      for (int k = 0; k < DEG; k++) v[k*LLR_W +: LLR_W] = LLR_W'($urandom_range(0, 63));
      drive(v, 1);
      drain();
    end

    repeat (3) @(negedge clk);
    summary();
  end

endmodule